// File: doc/BRIEF.md
# Byte-Serial SPI Master Transfer Engine

This block moves bytes between two on-chip FIFOs and a four-wire serial peripheral bus, acting as the bus master. Software-side logic writes a 17-bit configuration word and pushes transmit bytes into a 128-entry transmit queue. The engine takes each byte, shifts it out MSB first on `mosi`, and at the same time shifts in one byte from `miso`, which it places in a 128-entry receive queue. The serial clock is a power-of-two division of the block clock. Clock polarity and phase are selectable, so all four common SPI modes are covered.

Transfers begin as soon as bytes are queued, or they are held until a start trigger is written (manual start). The four slave-select lines either follow the transfer automatically or are driven continuously from the configuration word (manual select). A build-time option chooses between one-hot active-low selects and a binary index meant for an external decoder. Three level flags go to a separate interrupt block:

- transmit level below a programmable watermark
- transmit queue full
- receive queue not empty

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `cfg_q` reads 17'h03C09: bit 0 (master enable) set, divisor field bits 5:3 = 1, select field bits 13:10 = 4'b1111, all other bits 0. The watermark is 1, `tx_below_wm` is 1, `tx_full`, `rx_not_empty` and `busy` are 0, and `ss_n` is 4'b1111.
- R2: The divisor field N (bits 5:3) sets the serial half-period to 2^N block-clock cycles, and one byte keeps `busy` high for exactly 16*2^N cycles. N=0 behaves as N=1.
- R3: Bit 1 (CPOL) is the idle level of `sclk`. When bit 2 (CPHA) is 0, data is sampled on leading edges; when it is 1, data is sampled on trailing edges. Both directions are MSB first.
- R4: Every transmitted byte produces exactly one received byte, in order. A byte starts only while the receive queue has room.
- R5: A byte starts only when `eng_en` is 1 and configuration bit 0 is 1. While either is 0, queued bytes stay queued.
- R6: With bit 15 set, queued bytes wait. Writing bit 16 together with bit 15 releases them, and they drain with one idle cycle between bytes. Bit 16 reads 1 until the queue is empty and the engine is idle, then reads 0.
- R7: With bit 14 clear, `ss_n` carries the select field (bits 13:10) from the cycle after a byte starts until the cycle after the last byte ends, and reads 4'b1111 otherwise.
- R8: With bit 14 set, `ss_n` carries the select field continuously, one cycle after it is written, even with no transfer.
- R9: In the one-hot variant (DECODED_SS=0), a select field with more than one 0 bit drives `ss_n` to 4'b1111. In the decoded variant, the field passes through unchanged.
- R10: `tx_below_wm` is 1 exactly when the transmit count is less than the watermark.
- R11: `tx_full` is 1 when 128 bytes are queued, and a push while full is dropped.
- R12: `rx_data` shows the oldest received byte. A pop while the receive queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the serial clock reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Engine enable gate |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 17 | Configuration word to write |
| cfg_q | output | 17 | Current configuration word (bit 16 is the live start latch) |
| wm_we | input | 1 | Watermark write strobe |
| wm_wdata | input | 8 | Watermark value |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| tx_below_wm | output | 1 | Transmit count below watermark |
| tx_full | output | 1 | Transmit queue full |
| rx_not_empty | output | 1 | Receive queue holds data |
| busy | output | 1 | A byte is on the wire |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Slave-select lines |

## Verification
On every cycle, the assertions check these structural rules:
- no byte starts while the engine is disabled, or while it is held for a manual start that has not been triggered;
- each finished byte reaches the receive queue, and that queue is never full when a byte lands;
- `sclk` rests at the polarity level whenever the engine is idle;
- in the one-hot variant, at most one select line is ever low.

Only the bench scenarios can show the rest, because it depends on a bus partner: bit order and sampling edge for each mode, the exact byte duration for each divisor, the order of received data, the behaviour of the start trigger and select field, and the dropped push at a full queue.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
   localparam int WORD_W   = 8;
   localparam int SS_W     = 4;
   localparam int DIV_W    = 3;
   localparam int CFG_W    = 17;
   localparam int B_EN     = 0;
   localparam int B_CPOL   = 1;
   localparam int B_CPHA   = 2;
   localparam int B_DIV    = 3;
   localparam int B_SS     = 10;
   localparam int B_MSS    = 14;
   localparam int B_MST    = 15;
   localparam int B_GO     = 16;
   localparam logic [CFG_W-1:0] CFG_RST = 17'h03C09;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_byte_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_xfer_pkg::*; #(
   parameter int DW = WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DW-1:0]    din,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             miso,
   output logic             busy,
   output logic             done,
   output logic [DW-1:0]    dout,
   output logic             sclk,
   output logic             mosi
);
   if (DW < 2) begin : g_bad_dw
      $error("spi_shift_core: DW must be at least 2");
   end

   localparam int HC_W = 1 << DIV_W;
   localparam int EC_W = $clog2(2 * DW);
   localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * DW - 1);

   logic [DIV_W-1:0] eff_div;
   logic [HC_W-1:0]  half_last, hcnt;
   logic [EC_W-1:0]  ecnt;
   logic             phase, lead, smp, drv, edge_now;
   logic [DW-1:0]    tx_sr, rx_sr, rx_nxt;

   assign eff_div   = (div_sel == '0) ? DIV_W'(1) : div_sel;
   assign half_last = (HC_W'(1) << eff_div) - 1'b1;
   assign edge_now  = busy && (hcnt == half_last);
   assign lead      = ~ecnt[0];
   assign smp       = cpha ? ~lead : lead;
   assign drv       = ~smp;
   assign rx_nxt    = {rx_sr[DW-2:0], miso};
   assign sclk      = cpol ^ phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         dout  <= '0;
         hcnt  <= '0;
         ecnt  <= '0;
         phase <= 1'b0;
         tx_sr <= '0;
         rx_sr <= '0;
         mosi  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            hcnt  <= '0;
            ecnt  <= '0;
            phase <= 1'b0;
            tx_sr <= din;
            rx_sr <= '0;
            mosi  <= din[DW-1];
         end else if (edge_now) begin
            hcnt  <= '0;
            phase <= ~phase;
            ecnt  <= ecnt + 1'b1;
            if (smp) rx_sr <= rx_nxt;
            if (drv) begin
               mosi  <= cpha ? tx_sr[DW-1] : tx_sr[DW-2];
               tx_sr <= tx_sr << 1;
            end
            if (ecnt == LAST_EDGE) begin
               busy <= 1'b0;
               done <= 1'b1;
               dout <= smp ? rx_nxt : rx_sr;
            end
         end else if (busy) begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive import spi_xfer_pkg::*; #(
   parameter bit DECODED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SS_W-1:0] field,
   input  logic            manual,
   input  logic            active,
   output logic [SS_W-1:0] ss_n
);
   logic [SS_W-1:0] pick;

   if (DECODED) begin : g_decoded
      assign pick = field;
   end else begin : g_onehot
      logic legal;
      assign legal = ($countones(~field) <= 1);
      assign pick  = legal ? field : '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ss_n <= '1;
      else if (manual || active) ss_n <= pick;
      else                       ss_n <= '1;
   end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine import spi_xfer_pkg::*; #(
   parameter int  DEPTH      = 128,
   parameter bit  DECODED_SS = 1'b0,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_en,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_q,
   input  logic              wm_we,
   input  logic [CNT_W-1:0]  wm_wdata,
   input  logic              tx_push,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              rx_pop,
   output logic [WORD_W-1:0] rx_data,
   output logic              tx_below_wm,
   output logic              tx_full,
   output logic              rx_not_empty,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [SS_W-1:0]   ss_n
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_xfer_engine: DEPTH must be a power of two of at least 2");
   end

   logic [CFG_W-2:0]  cfg_lo;
   logic              go_q;
   logic [CNT_W-1:0]  wm_q, tx_cnt, rx_cnt;
   logic              tx_empty, rx_empty, rx_full;
   logic [WORD_W-1:0] tx_head, core_dout;
   logic              core_busy, core_done, run_en, can_go, start;

   assign cfg_q  = {go_q, cfg_lo};
   assign run_en = eng_en && cfg_lo[B_EN];
   assign can_go = !cfg_lo[B_MST] || go_q;
   assign start  = run_en && can_go && !core_busy && !tx_empty && !rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_lo <= CFG_RST[CFG_W-2:0];
         go_q   <= 1'b0;
         wm_q   <= CNT_W'(1);
      end else begin
         if (cfg_we) begin
            cfg_lo <= cfg_wdata[CFG_W-2:0];
            go_q   <= cfg_wdata[B_GO] && cfg_wdata[B_MST];
         end else if (go_q && tx_empty && !core_busy && !start) begin
            go_q <= 1'b0;
         end
         if (wm_we) wm_q <= wm_wdata;
      end
   end

   spi_byte_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data), .pop(start),
      .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
   );

   spi_byte_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(core_done), .wdata(core_dout), .pop(rx_pop),
      .rdata(rx_data), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
   );

   spi_shift_core #(.DW(WORD_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .din(tx_head),
      .div_sel(cfg_lo[B_DIV +: DIV_W]), .cpol(cfg_lo[B_CPOL]), .cpha(cfg_lo[B_CPHA]),
      .miso(miso), .busy(core_busy), .done(core_done), .dout(core_dout),
      .sclk(sclk), .mosi(mosi)
   );

   spi_ss_drive #(.DECODED(DECODED_SS)) u_ss (
      .clk(clk), .rst_n(rst_n), .field(cfg_lo[B_SS +: SS_W]), .manual(cfg_lo[B_MSS]),
      .active(core_busy || start), .ss_n(ss_n)
   );

   assign tx_below_wm  = (tx_cnt < wm_q);
   assign rx_not_empty = !rx_empty;
   assign busy         = core_busy;
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk import spi_xfer_pkg::*; #(
   parameter int  DEPTH      = 128,
   parameter bit  DECODED_SS = 1'b0,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eng_en,
   input logic [CFG_W-1:0] cfg_q,
   input logic             busy,
   input logic             core_done,
   input logic             rx_full,
   input logic             rx_not_empty,
   input logic [CNT_W-1:0] tx_cnt,
   input logic             sclk,
   input logic [SS_W-1:0]  ss_n
);
   // R5
   disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_en && !busy) |=> !busy);

   // R6
   held_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[B_MST] && !cfg_q[B_GO] && !busy) |=> !busy);

   // R4
   rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_done |-> !rx_full);

   // R4
   rx_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> rx_not_empty);

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cfg_q[B_CPOL]));

   // R11
   tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CNT_W'(DEPTH));

   if (!DECODED_SS) begin : g_onehot_chk
      // R9
      single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(~ss_n) <= 1);
   end
endmodule

bind spi_xfer_engine spi_xfer_chk #(.DEPTH(DEPTH), .DECODED_SS(DECODED_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_q(cfg_q), .busy(busy),
   .core_done(core_done), .rx_full(rx_full), .rx_not_empty(rx_not_empty),
   .tx_cnt(tx_cnt), .sclk(sclk), .ss_n(ss_n)
);

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        eng_en = 1'b0, cfg_we = 1'b0, wm_we = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
   logic [16:0] cfg_wdata = '0, cfg_q;
   logic [7:0]  wm_wdata = '0, tx_data = '0, rx_data;
   logic        tx_below_wm, tx_full, rx_not_empty, busy, sclk, mosi;
   logic        miso = 1'b0;
   logic [3:0]  ss_n;
   int          errs = 0, checks = 0;

   always #2.5 clk = ~clk;

   spi_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_q(cfg_q), .wm_we(wm_we), .wm_wdata(wm_wdata), .tx_push(tx_push), .tx_data(tx_data),
      .rx_pop(rx_pop), .rx_data(rx_data), .tx_below_wm(tx_below_wm), .tx_full(tx_full),
      .rx_not_empty(rx_not_empty), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   // bus partner model
   logic       s_cpol = 1'b0, s_cpha = 1'b0;
   int         s_idx, s_cnt, r_cnt, ncap;
   logic [7:0] s_out, r_sh;
   logic [7:0] cap [0:255];

   function automatic logic [7:0] reply(input int j);
      return 8'(j * 37 + 11);
   endfunction

   task automatic slave_reset(input logic cpol, input logic cpha);
      s_cpol = cpol; s_cpha = cpha;
      s_idx = 0; s_cnt = 0; r_cnt = 0; ncap = 0; r_sh = '0;
      s_out = reply(0);
      miso = s_out[7];
   endtask

   always @(sclk) begin
      if (rst_n && ss_n != 4'hF) begin
         logic lead, samp;
         lead = (sclk != s_cpol);
         samp = s_cpha ? !lead : lead;
         if (samp) begin
            r_sh = {r_sh[6:0], mosi};
            r_cnt++;
            if (r_cnt == 8) begin cap[ncap] = r_sh; ncap++; r_cnt = 0; end
         end else if (s_cpha) begin
            miso = s_out[7 - s_cnt];
            s_cnt++;
            if (s_cnt == 8) begin s_idx++; s_out = reply(s_idx); s_cnt = 0; end
         end else begin
            s_cnt++;
            if (s_cnt == 8) begin s_idx++; s_out = reply(s_idx); s_cnt = 0; miso = s_out[7]; end
            else miso = s_out[7 - s_cnt];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [16:0] mk_cfg(input logic go, input logic mst, input logic mss,
                                         input logic [3:0] ss, input logic [2:0] dv,
                                         input logic cpha, input logic cpol, input logic en);
      return {go, mst, mss, ss, 4'b0000, dv, cpha, cpol, en};
   endfunction

   task automatic wr_cfg(input logic [16:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk); tx_push = 1'b1; tx_data = b;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic pop_chk(input string req, input logic [7:0] exp);
      @(negedge clk);
      chk(req, rx_data, exp);
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic wait_quiet();
      int idle = 0;
      for (int i = 0; i < 20000 && idle < 8; i++) begin
         @(negedge clk);
         idle = busy ? 0 : idle + 1;
      end
   endtask

   // cpol, cpha, divisor field, byte
   localparam logic [12:0] VEC [6] = '{
      {1'b0, 1'b0, 3'd1, 8'hC3}, {1'b1, 1'b0, 3'd2, 8'h5A}, {1'b0, 1'b1, 3'd1, 8'h96},
      {1'b1, 1'b1, 3'd3, 8'h0F}, {1'b0, 1'b0, 3'd0, 8'hE1}, {1'b1, 1'b1, 3'd7, 8'h3C}};

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cfg", cfg_q, 17'h03C09);
      chk("R1 flags", {tx_below_wm, tx_full, rx_not_empty, busy}, 4'b1000);
      chk("R1 ss_n", ss_n, 4'hF);
      chk("R1 sclk", sclk, 1'b0);
      eng_en = 1'b1;

      // R2 R3 R4 R7: table of modes and divisors
      foreach (VEC[k]) begin
         logic       vp, vh;
         logic [2:0] vd;
         logic [7:0] vb;
         int         len, eff;
         logic [3:0] ss_seen;
         {vp, vh, vd, vb} = VEC[k];
         eff = (vd == 3'd0) ? 1 : int'(vd);
         wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 4'b1110, vd, vh, vp, 1'b1));
         @(negedge clk);
         chk("R3 idle level", sclk, vp);
         slave_reset(vp, vh);
         push(vb);
         for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
         ss_seen = ss_n;
         len = 0;
         while (busy && len < 5000) begin len++; @(negedge clk); end
         chk("R2 byte length", len, 16 << eff);
         chk("R7 auto select", ss_seen, 4'b1110);
         repeat (3) @(negedge clk);
         chk("R7 idle select", ss_n, 4'hF);
         chk("R3 mosi byte", cap[0], vb);
         chk("R4 rx present", rx_not_empty, 1'b1);
         pop_chk("R3 miso byte", reply(0));
      end

      // R12 pop on empty has no effect
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 4'b1101, 3'd1, 1'b0, 1'b0, 1'b1));
      @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
      chk("R12 still empty", rx_not_empty, 1'b0);
      slave_reset(1'b0, 1'b0);
      push(8'h77); push(8'h88);
      wait_quiet();
      pop_chk("R12 head after empty pop", reply(0));
      pop_chk("R4 order", reply(1));

      // R5 engine gate
      eng_en = 1'b0;
      slave_reset(1'b0, 1'b0);
      push(8'h44);
      repeat (40) @(negedge clk);
      chk("R5 no transfer when disabled", {busy, rx_not_empty}, 2'b00);
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 4'b1101, 3'd1, 1'b0, 1'b0, 1'b0));
      eng_en = 1'b1;
      repeat (40) @(negedge clk);
      chk("R5 no transfer with enable bit clear", {busy, rx_not_empty}, 2'b00);
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 4'b1101, 3'd1, 1'b0, 1'b0, 1'b1));
      wait_quiet();
      chk("R5 runs once enabled", cap[0], 8'h44);
      pop_chk("R5 reply", reply(0));

      // R6 manual start
      slave_reset(1'b0, 1'b0);
      wr_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 4'b1110, 3'd1, 1'b0, 1'b0, 1'b1));
      push(8'h11); push(8'h22); push(8'h33);
      repeat (40) @(negedge clk);
      chk("R6 held", {busy, rx_not_empty, cfg_q[16]}, 3'b000);
      wr_cfg(mk_cfg(1'b1, 1'b1, 1'b0, 4'b1110, 3'd1, 1'b0, 1'b0, 1'b1));
      chk("R6 trigger reads set", cfg_q[16], 1'b1);
      wait_quiet();
      chk("R6 trigger self-clears", cfg_q[16], 1'b0);
      chk("R6 drained count", ncap, 3);
      chk("R6 last byte", cap[2], 8'h33);
      pop_chk("R6 rx0", reply(0));
      pop_chk("R6 rx1", reply(1));
      pop_chk("R6 rx2", reply(2));

      // R8 R9 manual select
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b1, 4'b1011, 3'd1, 1'b0, 1'b0, 1'b1));
      @(negedge clk);
      chk("R8 manual select", ss_n, 4'b1011);
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b1, 4'b0101, 3'd1, 1'b0, 1'b0, 1'b1));
      @(negedge clk);
      chk("R9 illegal pattern", ss_n, 4'hF);

      // R10 watermark
      wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 4'b1110, 3'd1, 1'b0, 1'b0, 1'b1));
      eng_en = 1'b0;
      @(negedge clk); wm_we = 1'b1; wm_wdata = 8'd3; @(negedge clk); wm_we = 1'b0;
      push(8'h01); push(8'h02);
      @(negedge clk);
      chk("R10 below at 2 of 3", tx_below_wm, 1'b1);
      push(8'h03);
      @(negedge clk);
      chk("R10 not below at 3 of 3", tx_below_wm, 1'b0);
      slave_reset(1'b0, 1'b0);
      eng_en = 1'b1;
      wait_quiet();
      chk("R10 below when empty", tx_below_wm, 1'b1);
      for (int i = 0; i < 3; i++) pop_chk("R10 flush", reply(i));

      // R11 full queue, dropped push, 128 bytes through
      eng_en = 1'b0;
      for (int i = 0; i < 129; i++) push(8'(i));
      chk("R11 full", tx_full, 1'b1);
      slave_reset(1'b0, 1'b0);
      eng_en = 1'b1;
      wait_quiet();
      chk("R11 bytes sent", ncap, 128);
      begin
         int bad = 0;
         for (int i = 0; i < 128; i++) if (cap[i] !== 8'(i)) bad++;
         chk("R11 sent data", bad, 0);
      end
      for (int i = 0; i < 128; i++) pop_chk("R4 rx stream", reply(i));
      chk("R4 rx drained", rx_not_empty, 1'b0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule